// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block forms the unsigned product of two WIDTH-bit operands over several clock cycles. A small three-state controller steers a datapath of three registers: a double-width multiplicand that moves one place toward the most significant end each step, a multiplier that moves one place toward the least significant end, and a double-width accumulator. In each compute step the multiplicand is added into the accumulator when the multiplier's lowest bit is set. The loop stops as soon as the multiplier register holds zero, so small multipliers finish sooner.

A user places both operands on the inputs while `start` is low, then raises `start`. The block raises `done` when the result is ready. It keeps the result steady for as long as `start` stays high. Lowering `start` returns the block to idle, ready for the next operation.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted and after its release, `done` reads 0 and `product` reads 0 until an operation is started.
- R2: When `done` is high, `product` equals `op_a * op_b` as unsigned numbers, where the operands are the values present at the last clock edge on which the idle block saw `start` low.
- R3: If k is the bit length of the latched multiplier (k = 0 for zero), `done` first reads 1 after the (k+2)-th rising edge, counted from and including the first edge on which the idle block samples `start` high.
- R4: Once `done` is high, it stays high while `start` stays high. It drops after the first edge that samples `start` low.
- R5: `product` does not change while `done` stays high.
- R6: Changes on `op_a` and `op_b` while `start` is high have no effect on the result.
- R7: After the block is back in idle, the first edge that samples `start` low clears `product` to 0.
- R8: With WIDTH = 4, the operands 13 and 11 give the product 143.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | High starts an operation and holds the result; low returns to idle and loads operands |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| product | output | 2*WIDTH | Accumulated product |
| done | output | 1 | Result ready |

## Verification
The bench sweeps every operand pair of a 4-bit configuration, including zero and all-ones multipliers. A design that failed to zero-extend the multiplicand would drop high product bits. A design with a wrong exit test would stop one step early, or would not stop at all on a zero multiplier. The latency of every pair is compared with the bit length of the multiplier, so an off-by-one in the early exit is caught. The operands are scrambled during each run to expose a block that reloads outside idle. The bench also holds `start` after completion and then drops it, which exposes a result that drifts while held or a block that never returns to idle.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_rst_sync.sv
module mul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mplier_zero,
  output logic       load_en,
  output logic       step_en,
  output logic       done,
  output mul_state_e state
);
  mul_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)       state_d = ST_RUN;
      ST_RUN:  if (mplier_zero) state_d = ST_DONE;
      ST_DONE: if (!start)      state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign load_en = (state_q == ST_IDLE) && !start;
  assign step_en = (state_q == ST_RUN) && !mplier_zero;
  assign done    = (state_q == ST_DONE);
  assign state   = state_q;
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               step_en,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic               mplier_zero,
  output logic [2*WIDTH-1:0] mcand,
  output logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] acc
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    mcand_q, mcand_d;
  logic [WIDTH-1:0] mplier_q, mplier_d;
  logic [PW-1:0]    acc_q, acc_d;
  logic             reg_en;

  assign reg_en = load_en | step_en;

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc_q;
    if (load_en) begin
      mcand_d  = {{WIDTH{1'b0}}, op_a};
      mplier_d = op_b;
      acc_d    = '0;
    end else if (step_en) begin
      if (mplier_q[0]) acc_d = acc_q + mcand_q;
      mcand_d  = {mcand_q[PW-2:0], 1'b0};
      mplier_d = {1'b0, mplier_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (reg_en) begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      acc_q    <= acc_d;
    end
  end

  assign mplier_zero = (mplier_q == '0);
  assign mcand       = mcand_q;
  assign mplier      = mplier_q;
  assign acc         = acc_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);
  import mul_pkg::*;

  logic             rst_sync_n;
  logic             load_en, step_en, mplier_zero;
  mul_state_e       state;
  logic [2*WIDTH-1:0] mcand;
  logic [WIDTH-1:0]   mplier;

  mul_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mul_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .mplier_zero (mplier_zero),
    .load_en     (load_en),
    .step_en     (step_en),
    .done        (done),
    .state       (state)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_en     (load_en),
    .step_en     (step_en),
    .op_a        (op_a),
    .op_b        (op_b),
    .mplier_zero (mplier_zero),
    .mcand       (mcand),
    .mplier      (mplier),
    .acc         (product)
  );
endmodule

// File: rtl/mul_chk.sv
module mul_chk
  import mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               start,
  input logic               done,
  input mul_state_e         state,
  input logic [WIDTH-1:0]   mplier,
  input logic [2*WIDTH-1:0] product
);
  // R3
  zero_exit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_RUN && mplier == '0) |=> done);

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && start) |=> done);

  // R4
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !start) |=> !done);

  // R5
  done_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && $past(done)) |-> $stable(product));

  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_IDLE && !start) |=> (product == '0));
endmodule

bind shift_add_mul mul_chk #(.WIDTH(WIDTH)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .start      (start),
  .done       (done),
  .state      (state),
  .mplier     (mplier),
  .product    (product)
);

// File: tb/shift_add_mul_tb_top.sv
module shift_add_mul_tb_top;
  localparam int W = 4;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [W-1:0]   op_a, op_b;
  logic [2*W-1:0] product;
  logic           done;

  int total = 0;
  int bad   = 0;

  shift_add_mul #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_a(op_a), .op_b(op_b), .product(product), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int bitlen(input int v);
    int n = 0;
    while (v != 0) begin n++; v = v >> 1; end
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_mul(input int a, input int b);
    int cnt;
    int snap;
    @(negedge clk);
    op_a = a[W-1:0]; op_b = b[W-1:0]; start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      // R6: scramble operands while busy
      op_a = ~op_a; op_b = op_b + 4'd5;
    end while (!done && cnt < 40);
    // R3
    check(cnt == bitlen(b) + 2, "R3 latency", cnt, bitlen(b) + 2);
    // R2, R6
    check(product == a * b, "R2/R6 product", product, a * b);
    snap = product;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      op_a = op_a + 4'd3;
      // R4, R5
      check(done == 1'b1, "R4 done held", done, 1);
      check(product == snap, "R5 product stable", product, snap);
    end
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R4 done release", done, 0);
    @(negedge clk);
    check(product == 0, "R7 idle clear", product, 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    // R1
    check(done == 1'b0, "R1 reset done", done, 0);
    check(product == 0, "R1 reset product", product, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 post-reset done", done, 0);
    check(product == 0, "R1 post-reset product", product, 0);

    // R8
    run_mul(13, 11);
    @(negedge clk);
    op_a = 4'd13; op_b = 4'd11;
    @(negedge clk);
    start = 1'b1;
    repeat (6) @(negedge clk);
    check(product == 143, "R8 13x11", product, 143);
    start = 1'b0;
    repeat (2) @(negedge clk);

    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_mul(a, b);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule